// File: doc/BRIEF.md
# MSI Request Qualifier and Trigger

This block sits on the local side of a PCI Express endpoint and turns a level-style "please interrupt the host" signal into exactly one Message Signaled Interrupt request. The request line must stay high for a programmable run of consecutive clocks before it counts, which filters out short glitches. Once it counts, the block raises a one-clock send strobe toward the TLP generator. The MSI address and data that the remote Root Complex programmed into the MSI capability registers are latched and presented with that strobe.

After a send the block stays busy until the generator acknowledges. It then waits for the request line to fall before it will qualify a new request. The block only acts when the core is strapped as an Endpoint. In Root Complex mode, and whenever the MSI enable bit from configuration is clear, qualified requests are discarded.

Top module: `msi_trigger`

## Requirements
- R1: After reset `msi_send_o` and `msi_busy_o` are 0, and `msi_addr_o` and `msi_data_o` are all zeros.
- R2: With `ep_mode_i`=1 and `cfg_msi_en_i`=1, when `msi_req_i` is high at MIN_HIGH (default 2) consecutive rising edges while idle, `msi_send_o` is 1 in the clock period that follows the MIN_HIGH-th edge.
- R3: A high level that lasts fewer than MIN_HIGH edges produces no send, and any low sample restarts the count from zero.
- R4: A single continuous high level produces at most one send. `msi_req_i` must be sampled low before another request can qualify.
- R5: While `ep_mode_i`=0 (Root Complex mode) the request input has no effect: no send occurs and `msi_busy_o` stays 0.
- R6: A request that qualifies while `cfg_msi_en_i`=0 is dropped with no send. Setting the enable later during the same high level does not revive it.
- R7: `msi_addr_o` and `msi_data_o` take the values of `cfg_msi_addr_i` and `cfg_msi_data_i` at the edge that raises `msi_send_o`. They then hold those values until the next send.
- R8: `msi_busy_o` is 1 from the send cycle until the edge at which `msi_ack_i` is sampled high, and 0 after that edge. No send occurs while busy, and request activity during busy does not qualify.
- R9: `msi_send_o` is never high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_mode_i | input | 1 | 1 = Endpoint mode, 0 = Root Complex mode |
| msi_req_i | input | 1 | Level-sensitive MSI request |
| cfg_msi_en_i | input | 1 | MSI enable from configuration space |
| cfg_msi_addr_i | input | ADDR_W | MSI target address from configuration space |
| cfg_msi_data_i | input | DATA_W | MSI data value from configuration space |
| msi_ack_i | input | 1 | Generator has taken the MSI |
| msi_send_o | output | 1 | One-clock request to emit the MSI memory write |
| msi_addr_o | output | ADDR_W | Latched MSI address |
| msi_data_o | output | DATA_W | Latched MSI data |
| msi_busy_o | output | 1 | MSI outstanding, waiting for acknowledge |

## Verification
The assertions take for granted that `msi_req_i`, `ep_mode_i` and the configuration inputs are already synchronous to `clk`. They also assume that `msi_ack_i` has meaning only while busy, so an acknowledge arriving when nothing is outstanding is not treated as an error. The bench honours this by driving every input on the falling edge. Its acknowledge responder raises `msi_ack_i` only after it has seen `msi_busy_o` high, and for a single clock. The mode and enable inputs are changed only while the request line is low or within a deliberate R6 scenario.

// File: rtl/msi_trig_pkg.sv
package msi_trig_pkg;

    localparam int DEF_MIN_HIGH = 2;
    localparam int DEF_ADDR_W   = 64;
    localparam int DEF_DATA_W   = 32;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_BUSY     = 2'd1,
        ST_WAIT_LOW = 2'd2
    } trig_state_e;

    typedef struct packed {
        logic qualified;
        logic enabled;
    } qual_evt_t;

    // where to go once the generator has taken the message
    function automatic trig_state_e state_after_ack(input logic lvl);
        return lvl ? ST_WAIT_LOW : ST_IDLE;
    endfunction

endpackage

// File: rtl/msi_level_qualifier.sv
module msi_level_qualifier #(
    parameter int MIN_HIGH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic lvl_i,
    output logic qualified_o
);
    localparam int CNT_W = (MIN_HIGH > 1) ? $clog2(MIN_HIGH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_HIGH - 1);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (arm_i && lvl_i) begin
            if (run_q != LAST)
                run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assign qualified_o = arm_i && lvl_i && (run_q >= LAST);

endmodule

// File: rtl/msi_send_ctrl.sv
module msi_send_ctrl
    import msi_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  qual_evt_t evt_i,
    input  logic      lvl_i,
    input  logic      ack_i,
    output logic      send_o,
    output logic      capture_o,
    output logic      idle_o,
    output logic      busy_o
);
    trig_state_e state_q;

    assign idle_o    = (state_q == ST_IDLE);
    assign busy_o    = (state_q == ST_BUSY);
    assign capture_o = idle_o && evt_i.qualified && evt_i.enabled;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            send_o  <= 1'b0;
        end else begin
            send_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (evt_i.qualified) begin
                        if (evt_i.enabled) begin
                            send_o  <= 1'b1;
                            state_q <= ST_BUSY;
                        end else begin
                            state_q <= ST_WAIT_LOW;
                        end
                    end
                end
                ST_BUSY: begin
                    if (ack_i)
                        state_q <= state_after_ack(lvl_i);
                end
                ST_WAIT_LOW: begin
                    if (!lvl_i)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/msi_payload_hold.sv
module msi_payload_hold #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            data_o <= '0;
        end else if (capture_i) begin
            addr_o <= addr_i;
            data_o <= data_i;
        end
    end

endmodule

// File: rtl/msi_trigger.sv
module msi_trigger
    import msi_trig_pkg::*;
#(
    parameter int MIN_HIGH = DEF_MIN_HIGH,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ep_mode_i,
    input  logic              msi_req_i,
    input  logic              cfg_msi_en_i,
    input  logic [ADDR_W-1:0] cfg_msi_addr_i,
    input  logic [DATA_W-1:0] cfg_msi_data_i,
    input  logic              msi_ack_i,
    output logic              msi_send_o,
    output logic [ADDR_W-1:0] msi_addr_o,
    output logic [DATA_W-1:0] msi_data_o,
    output logic              msi_busy_o
);
    logic      idle;
    logic      qualified;
    logic      capture;
    qual_evt_t evt;

    msi_level_qualifier #(.MIN_HIGH(MIN_HIGH)) qual_i (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (idle && ep_mode_i),
        .lvl_i       (msi_req_i),
        .qualified_o (qualified)
    );

    assign evt.qualified = qualified;
    assign evt.enabled   = cfg_msi_en_i;

    msi_send_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .lvl_i     (msi_req_i),
        .ack_i     (msi_ack_i),
        .send_o    (msi_send_o),
        .capture_o (capture),
        .idle_o    (idle),
        .busy_o    (msi_busy_o)
    );

    msi_payload_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) hold_i (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .addr_i    (cfg_msi_addr_i),
        .data_i    (cfg_msi_data_i),
        .addr_o    (msi_addr_o),
        .data_o    (msi_data_o)
    );

endmodule

// File: rtl/msi_trigger_chk.sv
module msi_trigger_chk #(
    parameter int MIN_HIGH = 2,
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ep_mode_i,
    input logic              msi_req_i,
    input logic              cfg_msi_en_i,
    input logic              msi_ack_i,
    input logic              msi_send_o,
    input logic [ADDR_W-1:0] msi_addr_o,
    input logic [DATA_W-1:0] msi_data_o,
    input logic              msi_busy_o
);
    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= '0;
        else if (!msi_req_i)
            hi_run <= '0;
        else if (hi_run != 16'hFFFF)
            hi_run <= hi_run + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !msi_send_o && !msi_busy_o); // R1
    AST_MIN_RUN: assert property (@(posedge clk) disable iff (rst)
        msi_send_o |-> (hi_run >= 16'(MIN_HIGH))); // R2
    AST_EP_ONLY: assert property (@(posedge clk) disable iff (rst)
        msi_send_o |-> $past(ep_mode_i)); // R5
    AST_EN_NEEDED: assert property (@(posedge clk) disable iff (rst)
        msi_send_o |-> $past(cfg_msi_en_i)); // R6
    AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !msi_send_o |-> $stable(msi_addr_o) && $stable(msi_data_o)); // R7
    AST_BUSY_ON_SEND: assert property (@(posedge clk) disable iff (rst)
        msi_send_o |-> msi_busy_o); // R8
    AST_NO_SEND_BUSY: assert property (@(posedge clk) disable iff (rst)
        $past(msi_busy_o) |-> !msi_send_o); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        msi_busy_o && msi_ack_i |=> !msi_busy_o); // R8
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        msi_send_o |=> !msi_send_o); // R9

endmodule

bind msi_trigger msi_trigger_chk #(
    .MIN_HIGH(MIN_HIGH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .ep_mode_i    (ep_mode_i),
    .msi_req_i    (msi_req_i),
    .cfg_msi_en_i (cfg_msi_en_i),
    .msi_ack_i    (msi_ack_i),
    .msi_send_o   (msi_send_o),
    .msi_addr_o   (msi_addr_o),
    .msi_data_o   (msi_data_o),
    .msi_busy_o   (msi_busy_o)
);

// File: tb/msi_trigger_tb_top.sv
module msi_trigger_tb_top;
    localparam int AW = 64;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ep_mode = 1'b1;
    logic          req = 1'b0;
    logic          en = 1'b1;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_data = '0;
    logic          ack = 1'b0;
    logic          send;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          busy;

    int errors = 0;
    int checks = 0;
    int sends  = 0;
    int ack_delay = 0;
    bit done = 1'b0;

    logic [AW+DW-1:0] exp_q[$];

    always #10 clk = ~clk;

    msi_trigger dut_i (
        .clk(clk), .rst(rst), .ep_mode_i(ep_mode), .msi_req_i(req),
        .cfg_msi_en_i(en), .cfg_msi_addr_i(cfg_addr), .cfg_msi_data_i(cfg_data),
        .msi_ack_i(ack), .msi_send_o(send), .msi_addr_o(addr),
        .msi_data_o(data), .msi_busy_o(busy)
    );

    task automatic check(input bit ok, input string rq, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_msi(input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic pulse_req(input int len);
        @(negedge clk); req = 1'b1;
        repeat (len) @(negedge clk);
        req = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // monitor side of the scoreboard (R7 payload compare)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && send) begin
                sends++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected send", 96'(1), 96'(0));
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    check({addr, data} == e, "R7 payload", {addr, data}, e);
                end
            end
        end
    end

    // acknowledge responder (R8 busy release)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && busy) begin
                repeat (ack_delay) begin
                    check(busy == 1'b1, "R8 busy held", 96'(busy), 96'(1));
                    @(negedge clk);
                end
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
                check(busy == 1'b0, "R8 busy cleared by ack", 96'(busy), 96'(0));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 96'(0), 96'(1));
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(send == 1'b0 && busy == 1'b0, "R1 strobes", {send, busy}, 96'(0));
        check(addr == '0 && data == '0, "R1 payload", {addr, data}, 96'(0));

        // R2 exact timing
        cfg_addr = 64'h1122_3344_5566_7788; cfg_data = 32'hCAFE_0001;
        expect_msi(cfg_addr, cfg_data);
        s0 = sends;
        req = 1'b1;
        @(posedge clk); @(negedge clk);
        check(send == 1'b0, "R2 not yet after one edge", 96'(send), 96'(0));
        @(posedge clk); @(negedge clk);
        check(send == 1'b1, "R2 send after second edge", 96'(send), 96'(1));
        @(negedge clk);
        check(send == 1'b0, "R9 single cycle", 96'(send), 96'(0));
        req = 1'b0;
        repeat (8) @(negedge clk);
        check(sends - s0 == 1, "R2 one send", 96'(sends - s0), 96'(1));

        // R3 short pulses
        s0 = sends;
        pulse_req(1);
        check(sends == s0, "R3 single clock pulse", 96'(sends - s0), 96'(0));
        @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
        @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
        repeat (8) @(negedge clk);
        check(sends == s0, "R3 count restarts on low", 96'(sends - s0), 96'(0));

        // R4 long level gives one send, then a new assertion gives another
        cfg_addr = 64'hA5A5_0000_0000_1000; cfg_data = 32'h0000_00FF;
        expect_msi(cfg_addr, cfg_data);
        s0 = sends;
        pulse_req(20);
        check(sends - s0 == 1, "R4 one send per level", 96'(sends - s0), 96'(1));
        cfg_addr = 64'hFFFF_FFFF_FFFF_FFFC; cfg_data = 32'hFFFF_FFFF;
        expect_msi(cfg_addr, cfg_data);
        s0 = sends;
        pulse_req(2);
        check(sends - s0 == 1, "R4 rearm after low", 96'(sends - s0), 96'(1));

        // R5 Root Complex mode
        ep_mode = 1'b0;
        s0 = sends;
        @(negedge clk); req = 1'b1;
        repeat (6) @(negedge clk);
        check(busy == 1'b0, "R5 busy stays low", 96'(busy), 96'(0));
        req = 1'b0;
        repeat (4) @(negedge clk);
        check(sends == s0, "R5 ignored in RC mode", 96'(sends - s0), 96'(0));
        ep_mode = 1'b1;

        // R6 disabled then enabled during same level
        en = 1'b0;
        s0 = sends;
        @(negedge clk); req = 1'b1;
        repeat (4) @(negedge clk);
        en = 1'b1;
        repeat (5) @(negedge clk);
        req = 1'b0;
        repeat (6) @(negedge clk);
        check(sends == s0, "R6 dropped while disabled", 96'(sends - s0), 96'(0));

        // R7 payload holds after config changes; R8 busy window ignores request
        ack_delay = 6;
        cfg_addr = 64'h0000_0000_FEE0_0000; cfg_data = 32'h0000_4021;
        expect_msi(cfg_addr, cfg_data);
        s0 = sends;
        @(negedge clk); req = 1'b1;
        @(negedge clk); @(negedge clk);
        req = 1'b0;
        cfg_addr = 64'h0; cfg_data = 32'h0;
        @(negedge clk);
        check(busy == 1'b1, "R8 busy after send", 96'(busy), 96'(1));
        req = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        req = 1'b0;
        check(addr == 64'h0000_0000_FEE0_0000 && data == 32'h0000_4021,
              "R7 payload held", {addr, data}, {64'h0000_0000_FEE0_0000, 32'h0000_4021});
        repeat (12) @(negedge clk);
        check(sends - s0 == 1, "R8 no send during busy", 96'(sends - s0), 96'(1));
        check(busy == 1'b0, "R8 idle after ack", 96'(busy), 96'(0));
        ack_delay = 0;

        check(exp_q.size() == 0, "R2 scoreboard drained", 96'(exp_q.size()), 96'(0));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule